// File: doc/BRIEF.md
# Variable-Region Address Translator

This block is a small, fully associative translation buffer for one address space. Each slot maps a naturally aligned region whose size is a power of two, from 4 KiB up to 128 MiB. Slots of different sizes can be resident at once. A virtual address comes in on a valid/ready request channel. It is compared against every valid slot in parallel. Each compare ignores the address bits that fall inside that slot's region. The translated physical address, or a miss, leaves on a valid/ready response channel.

The block never refills itself. On a miss it raises a miss flag with the response and latches the faulting virtual address, so software can choose a slot and install the mapping through the write port. Software can also remove one slot, or drop every slot at once with the global invalidate input.

Back-pressure works as follows. The pipeline has two stages: a request stage and a response stage. It advances only when the response register is empty or `rsp_ready` is high. `req_ready` follows that same advance condition. While `rsp_valid` is high and `rsp_ready` is low, the response and the pending request are both frozen. A request accepted on clock edge E is looked up during the following cycle, and its response is valid after edge E+1.

Top module: `vrt_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, `fault_vaddr` is 0 and every slot is invalid, so the first lookup misses.
- R2: A hit with size code k (4 bits, region 2^(12+k) bytes) returns the slot's physical base in bits [31:12+k] and the request's own address in bits [11+k:0].
- R3: Slots with different size codes match at the same time, each over its own region. An address one byte past a region's end does not match that slot.
- R4: A lookup that matches no valid slot returns `rsp_miss`=1 and `rsp_paddr`=0, and loads `fault_vaddr` with that virtual address. `fault_vaddr` keeps this value across later hits.
- R5: When several valid slots match, the slot with the lowest index supplies the translation.
- R6: A slot write is seen by lookups evaluated in the cycles after the write. A lookup evaluated in the same cycle as the write, which is the cycle after its request was accepted, uses the old contents.
- R7: `inv_all` clears every valid bit in one cycle. It overrides a slot write in the same cycle.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_paddr`/`rsp_miss` hold their values.
- R9: Writing a slot with `wr_valid`=0 removes it from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address (0 on miss) |
| rsp_miss | output | 1 | No valid slot matched |
| fault_vaddr | output | 32 | Virtual address of the latest miss |
| inv_all | input | 1 | Clear all valid bits |
| wr_en | input | 1 | Write one slot |
| wr_idx | input | 5 | Slot index |
| wr_vbase | input | 32 | Virtual base (aligned to region) |
| wr_pbase | input | 32 | Physical base (aligned to region) |
| wr_size | input | 4 | Size code k |
| wr_valid | input | 1 | Valid bit written to the slot |

## Verification
The bench sweeps sixteen slots, one for each size code, and probes each region at its base, at its last byte, at an interior point and one byte past its end. A design that masks one bit too many or too few fails the last-byte or the past-end probe. Overlapping slots are installed in both index orders. A priority encoder that favours the highest index, or that ORs the candidate addresses together, returns the wrong base. Three further cases are driven directly:
- a write landing in the same cycle as a pending lookup, which a design that forwards the write would get wrong;
- an invalidate that collides with a write, which a design letting the write win would get wrong;
- a stalled response, where a design that leaks the next result would change `rsp_paddr` under back-pressure.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
  localparam int ADDR_W    = 32;
  localparam int SZ_W      = 4;
  localparam int MIN_SHIFT = 12;

  typedef struct packed {
    logic              vld;
    logic [SZ_W-1:0]   sz;
    logic [ADDR_W-1:0] vb;
    logic [ADDR_W-1:0] pb;
  } vrt_slot_t;

  // ones over the compared (upper) bits of a region with size code sz
  function automatic logic [ADDR_W-1:0] region_mask(input logic [SZ_W-1:0] sz);
    logic [ADDR_W-1:0] ones;
    ones = '1;
    return ones << (MIN_SHIFT + int'(sz));
  endfunction
endpackage

// File: rtl/vrt_table.sv
module vrt_table
  import vrt_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inv_all,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  vrt_slot_t                 wr_slot,
  output vrt_slot_t [ENTRIES-1:0]   slots
);
  vrt_slot_t [ENTRIES-1:0] slot_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || inv_all) begin
        slot_q[i].vld <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        slot_q[i].vld <= wr_slot.vld;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[i].sz <= '0;
        slot_q[i].vb <= '0;
        slot_q[i].pb <= '0;
      end else if (wr_en && !inv_all && wr_idx == IDX_W'(i)) begin
        slot_q[i].sz <= wr_slot.sz;
        slot_q[i].vb <= wr_slot.vb;
        slot_q[i].pb <= wr_slot.pb;
      end
    end
  end

  assign slots = slot_q;

  // R7
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (slot_q[0].vld == 1'b0 && slot_q[ENTRIES-1].vld == 1'b0));

  // R9
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all) |=> slot_q[$past(wr_idx)].vld == $past(wr_slot.vld));
endmodule

// File: rtl/vrt_match.sv
module vrt_match
  import vrt_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  vrt_slot_t [ENTRIES-1:0] slots,
  input  logic [ADDR_W-1:0]       va,
  output logic [ENTRIES-1:0]      hit
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [ADDR_W-1:0] msk;
    assign msk    = region_mask(slots[i].sz);
    assign hit[i] = slots[i].vld && (((va ^ slots[i].vb) & msk) == '0);
  end
endmodule

// File: rtl/vrt_pick.sv
module vrt_pick
  import vrt_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  vrt_slot_t [ENTRIES-1:0] slots,
  input  logic [ENTRIES-1:0]      hit,
  input  logic [ADDR_W-1:0]       va,
  output logic                    any_hit,
  output logic [ADDR_W-1:0]       pa
);
  always_comb begin
    logic [ADDR_W-1:0] msk;
    any_hit = |hit;
    pa      = '0;
    msk     = '0;
    // walk downward so the lowest matching index is the last one assigned
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        msk = region_mask(slots[i].sz);
        pa  = (slots[i].pb & msk) | (va & ~msk);
      end
    end
  end
endmodule

// File: rtl/vrt_xlate.sv
module vrt_xlate
  import vrt_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_miss,
  output logic [ADDR_W-1:0] fault_vaddr,
  input  logic              inv_all,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_vbase,
  input  logic [ADDR_W-1:0] wr_pbase,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic              wr_valid
);
  vrt_slot_t [ENTRIES-1:0] slots;
  vrt_slot_t               wr_slot;
  logic [ENTRIES-1:0]      hit;
  logic                    any_hit;
  logic [ADDR_W-1:0]       lk_pa;
  logic                    advance;
  logic                    s1_valid;
  logic [ADDR_W-1:0]       s1_va;
  logic [ADDR_W-1:0]       s2_va;

  assign wr_slot = '{vld: wr_valid, sz: wr_size, vb: wr_vbase, pb: wr_pbase};

  vrt_table #(.ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_slot(wr_slot), .slots(slots)
  );

  vrt_match #(.ENTRIES(ENTRIES)) u_match (.slots(slots), .va(s1_va), .hit(hit));

  vrt_pick #(.ENTRIES(ENTRIES)) u_pick (
    .slots(slots), .hit(hit), .va(s1_va), .any_hit(any_hit), .pa(lk_pa)
  );

  assign advance   = !rsp_valid || rsp_ready;
  assign req_ready = advance;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_va       <= '0;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_miss    <= 1'b0;
      s2_va       <= '0;
      fault_vaddr <= '0;
    end else if (advance) begin
      s1_valid  <= req_valid;
      s1_va     <= req_valid ? req_vaddr : s1_va;
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_paddr <= any_hit ? lk_pa : '0;
        rsp_miss  <= !any_hit;
        s2_va     <= s1_va;
        if (!any_hit) fault_vaddr <= s1_va;
      end
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_miss)));

  // R4
  fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (fault_vaddr == s2_va && rsp_paddr == '0));

  // R2
  offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss) |-> rsp_paddr[MIN_SHIFT-1:0] == s2_va[MIN_SHIFT-1:0]);

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/tb_vrt_xlate.sv
module tb_vrt_xlate;
  localparam int CLK_P = 10;
  localparam int N = 32;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, rsp_ready = 1, inv_all = 0, wr_en = 0, wr_valid = 0;
  logic [31:0] req_vaddr = 0, wr_vbase = 0, wr_pbase = 0;
  logic [4:0]  wr_idx = 0;
  logic [3:0]  wr_size = 0;
  logic        req_ready, rsp_valid, rsp_miss;
  logic [31:0] rsp_paddr, fault_vaddr;

  int vectors = 0, errors = 0;
  bit done = 0;

  logic        m_vld [N];
  logic [3:0]  m_sz  [N];
  logic [31:0] m_vb  [N];
  logic [31:0] m_pb  [N];

  always #(CLK_P/2) clk = ~clk;

  vrt_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_miss(rsp_miss), .fault_vaddr(fault_vaddr),
    .inv_all(inv_all), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vbase(wr_vbase),
    .wr_pbase(wr_pbase), .wr_size(wr_size), .wr_valid(wr_valid)
  );

  function automatic logic [32:0] model(input logic [31:0] va);
    for (int i = 0; i < N; i++) begin
      logic [31:0] span;
      span = 32'd1 << (12 + m_sz[i]);
      if (m_vld[i] && (va / span) == (m_vb[i] / span))
        return {1'b0, (m_pb[i] / span) * span + (va % span)};
    end
    return {1'b1, 32'd0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] vb, input logic [31:0] pb,
                     input logic [3:0] sz, input logic v);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_vbase = vb; wr_pbase = pb; wr_size = sz; wr_valid = v;
    @(negedge clk);
    wr_en = 0;
    m_vld[idx] = v; m_sz[idx] = sz; m_vb[idx] = vb; m_pb[idx] = pb;
  endtask

  task automatic lookup(input string req, input logic [31:0] va);
    logic [32:0] e;
    e = model(va);
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check(req, {31'd0, rsp_valid, rsp_miss, rsp_paddr}, {31'd0, 1'b1, e});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_sz[i] = 0; m_vb[i] = 0; m_pb[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {rsp_valid, req_ready, fault_vaddr}, {1'b0, 1'b1, 32'd0});
    lookup("R1 empty table misses", 32'h1234_5678);

    // R2 R3 sweep: slot i has size code i, one region per 256 MiB window
    for (int i = 0; i < 16; i++)
      put(i, 32'(i) << 28, 32'((i * 7 + 3) % 16) << 28, 4'(i), 1'b1);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] b, s;
      b = 32'(i) << 28;
      s = 32'd1 << (12 + i);
      lookup("R2 region base", b);
      lookup("R2 region last byte", b + s - 1);
      lookup("R3 interior", b + (s >> 1) + 32'h123);
      lookup("R3 one past end", b + s);
    end

    // R4 fault capture and hold
    lookup("R4 miss", 32'h0ABC_DEF0);
    check("R4 fault_vaddr", {32'd0, fault_vaddr}, {32'd0, 32'h0ABC_DEF0});
    lookup("R4 hit after miss", 32'h3000_0010);
    check("R4 fault_vaddr held", {32'd0, fault_vaddr}, {32'd0, 32'h0ABC_DEF0});

    // R5 priority: higher index overlaps slot 1, then lower index overlaps
    put(20, 32'h1000_0000, 32'hAAAA_0000, 4'd0, 1'b1);
    lookup("R5 lower index wins over 20", 32'h1000_0044);
    put(0, 32'h1000_0000, 32'h5000_0000, 4'd5, 1'b1);
    lookup("R5 slot 0 wins", 32'h1000_1044);
    put(1, 32'h1000_0000, 32'h1000_0000, 4'd1, 1'b0);
    put(0, 32'h0000_0000, 32'h0000_0000, 4'd0, 1'b1);
    lookup("R5 slot 20 after lower removed", 32'h1000_0044);

    // R6 same-cycle write is not seen
    begin
      logic [32:0] old_e;
      old_e = model(32'h5000_0ABC);
      @(negedge clk);
      req_valid = 1; req_vaddr = 32'h5000_0ABC;
      @(negedge clk);
      req_valid = 0;
      wr_en = 1; wr_idx = 5; wr_vbase = 32'h5000_0000; wr_pbase = 32'hE000_0000;
      wr_size = 4'd5; wr_valid = 1;
      @(negedge clk);
      wr_en = 0;
      m_pb[5] = 32'hE000_0000;
      check("R6 same-cycle write unseen", {31'd0, rsp_valid, rsp_miss, rsp_paddr},
            {31'd0, 1'b1, old_e});
      lookup("R6 write seen afterwards", 32'h5000_0ABC);
    end

    // R9 removal of a single slot
    put(7, 32'h7000_0000, 32'h0, 4'd7, 1'b0);
    lookup("R9 removed slot misses", 32'h7000_0100);
    lookup("R9 neighbour still hits", 32'h8000_0100);

    // R8 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vaddr = 32'h9000_0004;
    @(negedge clk);
    req_vaddr = 32'h2000_0008;
    @(negedge clk);
    held = rsp_paddr;
    check("R8 stalled response valid", {62'd0, rsp_valid, req_ready}, {62'd0, 1'b1, 1'b0});
    check("R8 first response", {31'd0, rsp_valid, rsp_miss, rsp_paddr},
          {31'd0, 1'b1, model(32'h9000_0004)});
    repeat (3) @(negedge clk);
    check("R8 response held", {31'd0, rsp_valid, rsp_miss, rsp_paddr},
          {31'd0, 1'b1, 1'b0, held});
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    check("R8 queued response", {31'd0, rsp_valid, rsp_miss, rsp_paddr},
          {31'd0, 1'b1, model(32'h2000_0008)});
    @(negedge clk);
    check("R8 drained", {63'd0, rsp_valid}, 64'd0);

    // R7 invalidate beats a simultaneous write
    @(negedge clk);
    inv_all = 1; wr_en = 1; wr_idx = 2; wr_vbase = 32'h2000_0000;
    wr_pbase = 32'h4000_0000; wr_size = 4'd2; wr_valid = 1;
    @(negedge clk);
    inv_all = 0; wr_en = 0;
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    lookup("R7 written slot invalid", 32'h2000_0010);
    lookup("R7 slot 0 invalid", 32'h0000_0010);
    lookup("R7 slot 15 invalid", 32'hF000_0010);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule